// File: doc/BRIEF.md
# I2C Bus Clock Generator

This block produces the serial clock of an I2C master from a fast reference clock. Each SCL period has a low phase and a high phase. Their lengths are set by a programmable divider and by one of a few low-to-high weightings. A fixed number of extra reference cycles per period stands for the time needed to resynchronise to the wired SCL line. The block drives SCL as an open-drain output: it either pulls the line low or releases it. It also reads the line back, so a slave that holds SCL low stretches the clock.

For a bit engine placed beside it, the block gives three single-cycle strobes. The first marks the start of each low phase. The second marks the point where the line has been seen high and the high count starts. The third marks the middle of the high count, which is where a bit engine samples SDA. The weighting and the divider are captured once per period, at the start of the low phase. A change made during a period therefore takes effect cleanly at the next falling edge.

Top module: `sclClockGen`

## Requirements
- R1: The ratio select picks Nlow/Nhigh units. Code 0 gives 4/4, code 1 gives 6/3 and code 2 gives 11/6. With effective divider D and no stretching, SCL is driven low (`sclOe`=1) for exactly Nlow·(D+1) consecutive cycles.
- R2: Ratio code 3 produces the same timing as code 0 (4 low, 4 high units).
- R3: Without stretching, the time between consecutive `fallStb` pulses is (Nlow+Nhigh)·(D+1)+OVH cycles, where OVH is the overhead parameter (default 8, at least 4).
- R4: When `slaveMode` is 1 and the divider input is 0, the effective divider is 1.
- R5: A divider input above 2^DIV_W−1 is clamped to 2^DIV_W−1.
- R6: While `enable` is 0, SCL is released and all three strobes stay 0. One cycle after `enable` rises, `fallStb` pulses and SCL is driven low.
- R7: After SCL is released, the rise strobe comes only once `sclIn` has been sampled high for OVH/2 clock edges. While `sclIn` is held low the block waits and does not time out.
- R8: `riseStb` pulses OVH/2 cycles after SCL is released. `midHighStb` pulses floor(Nhigh·(D+1)/2) cycles after `riseStb`. The three strobes are never active in the same cycle.
- R9: Ratio, divider and slave-mode inputs are captured only at the start of each low phase. A change made during a period alters the next period, not the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; 0 releases SCL and clears counters |
| ratioSel | input | 2 | Low/high weighting code |
| divIn | input | DIV_W+2 | Requested divider value (clamped) |
| slaveMode | input | 1 | Forces a zero divider to 1 |
| sclIn | input | 1 | Sampled level of the SCL line |
| sclOe | output | 1 | 1 pulls SCL low, 0 releases it |
| fallStb | output | 1 | First cycle of the low phase |
| riseStb | output | 1 | First cycle of the counted high phase |
| midHighStb | output | 1 | Middle of the counted high phase |

## Verification
The bench builds the block with DIV_W=3 and the default overhead of 8. This keeps the longest period at 144 cycles. With these values the whole cross of all four ratio codes, divider inputs 0 to 9 and both slave-mode settings can be run and measured edge by edge against the period formula. The narrow divider field means inputs 8 and 9 go past the clamp point, and input 0 with slave mode exercises the forced minimum. Separate sequences hold SCL low after release to exercise stretching, and change the ratio in the middle of a low phase.

// File: rtl/sclPkg.sv
package sclPkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LOW  = 3'd1,
    PH_RISE = 3'd2,
    PH_HIGH = 3'd3,
    PH_FALL = 3'd4
  } phase_t;

  // Strobes from control into the datapath
  typedef struct packed {
    logic load;  // capture configuration into phase lengths
    logic clr;   // zero the phase counter
    logic inc;   // advance the phase counter
  } sclStrb_t;
endpackage

// File: rtl/sclDatapath.sv
module sclDatapath
  import sclPkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int DIV_IN_W = DIV_W + 2,
  parameter int OVH_LH   = 4,
  parameter int OVH_HL   = 4,
  parameter int LEN_W    = DIV_W + 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          ratioSel,
  input  logic [DIV_IN_W-1:0] divIn,
  input  logic                slaveMode,
  input  sclStrb_t            strb,
  output logic                atLowEnd,
  output logic                atHighEnd,
  output logic                atLhEnd,
  output logic                atHlEnd,
  output logic                atZero,
  output logic                atMid
);
  localparam logic [DIV_IN_W-1:0] DIV_MAX = DIV_IN_W'((1 << DIV_W) - 1);

  logic [DIV_W-1:0] divClamp, divEff;
  logic [3:0]       nLow, nHigh;
  logic [LEN_W-1:0] scale, lowNext, highNext;
  logic [LEN_W-1:0] lowLen, highLen, cnt;

  always_comb begin
    divClamp = (divIn > DIV_MAX) ? DIV_MAX[DIV_W-1:0] : divIn[DIV_W-1:0];
    divEff   = (slaveMode && divClamp == '0) ? DIV_W'(1) : divClamp;
    case (ratioSel)
      2'd1:    begin nLow = 4'd6;  nHigh = 4'd3; end
      2'd2:    begin nLow = 4'd11; nHigh = 4'd6; end
      default: begin nLow = 4'd4;  nHigh = 4'd4; end
    endcase
    scale    = LEN_W'(divEff) + LEN_W'(1);
    lowNext  = LEN_W'(nLow) * scale;
    highNext = LEN_W'(nHigh) * scale;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowLen  <= '0;
      highLen <= '0;
      cnt     <= '0;
    end else begin
      if (strb.load) begin
        lowLen  <= lowNext;
        highLen <= highNext;
      end
      if (strb.clr)      cnt <= '0;
      else if (strb.inc) cnt <= cnt + LEN_W'(1);
    end
  end

  assign atLowEnd  = (cnt == lowLen - LEN_W'(1));
  assign atHighEnd = (cnt == highLen - LEN_W'(1));
  assign atLhEnd   = (cnt == LEN_W'(OVH_LH - 1));
  assign atHlEnd   = (cnt == LEN_W'(OVH_HL - 1));
  assign atZero    = (cnt == '0);
  assign atMid     = (cnt == (highLen >> 1));

  AST_SLAVE_MIN_DIV: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && slaveMode) |=> (highLen >= LEN_W'(6)));  // R4
  AST_DIV_CLAMPED: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (highLen <= LEN_W'(6) * (LEN_W'(DIV_MAX) + LEN_W'(1))));  // R5
  AST_CLR_INC_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.clr && strb.inc));  // R3
endmodule

// File: rtl/sclControl.sv
module sclControl
  import sclPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     sclIn,
  input  logic     atLowEnd,
  input  logic     atHighEnd,
  input  logic     atLhEnd,
  input  logic     atHlEnd,
  input  logic     atZero,
  input  logic     atMid,
  output sclStrb_t strb,
  output logic     sclOe,
  output logic     fallStb,
  output logic     riseStb,
  output logic     midHighStb
);
  phase_t phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    strb      = '0;
    if (!enable) begin
      phaseNext = PH_IDLE;
      strb.clr  = 1'b1;
    end else begin
      case (phase)
        PH_IDLE: begin
          phaseNext = PH_LOW;
          strb.load = 1'b1;
          strb.clr  = 1'b1;
        end
        PH_LOW: begin
          if (atLowEnd) begin phaseNext = PH_RISE; strb.clr = 1'b1; end
          else strb.inc = 1'b1;
        end
        PH_RISE: begin
          if (sclIn) begin
            if (atLhEnd) begin phaseNext = PH_HIGH; strb.clr = 1'b1; end
            else strb.inc = 1'b1;
          end
        end
        PH_HIGH: begin
          if (atHighEnd) begin phaseNext = PH_FALL; strb.clr = 1'b1; end
          else strb.inc = 1'b1;
        end
        PH_FALL: begin
          if (atHlEnd) begin
            phaseNext = PH_LOW;
            strb.clr  = 1'b1;
            strb.load = 1'b1;
          end else strb.inc = 1'b1;
        end
        default: begin
          phaseNext = PH_IDLE;
          strb.clr  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign sclOe      = (phase == PH_LOW);
  assign fallStb    = (phase == PH_LOW) && atZero;
  assign riseStb    = (phase == PH_HIGH) && atZero;
  assign midHighStb = (phase == PH_HIGH) && atMid;

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (phase == PH_IDLE && !sclOe));  // R6
  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (enable && phase == PH_RISE && !sclIn) |=> (phase == PH_RISE));  // R7
  AST_RISE_AFTER_LINE: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |-> $past(sclIn));  // R7
  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fallStb, riseStb, midHighStb}));  // R8
  AST_FALL_AT_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclOe) |-> fallStb);  // R8
endmodule

// File: rtl/sclClockGen.sv
module sclClockGen
  import sclPkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OVH   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [1:0]       ratioSel,
  input  logic [DIV_W+1:0] divIn,
  input  logic             slaveMode,
  input  logic             sclIn,
  output logic             sclOe,
  output logic             fallStb,
  output logic             riseStb,
  output logic             midHighStb
);
  localparam int OVH_EFF = (OVH < 4) ? 4 : OVH;
  localparam int OVH_LH  = OVH_EFF / 2;
  localparam int OVH_HL  = OVH_EFF - OVH_LH;
  localparam int LEN_W   = DIV_W + 4;

  sclStrb_t strb;
  logic atLowEnd, atHighEnd, atLhEnd, atHlEnd, atZero, atMid;

  sclDatapath #(
    .DIV_W(DIV_W), .DIV_IN_W(DIV_W + 2),
    .OVH_LH(OVH_LH), .OVH_HL(OVH_HL), .LEN_W(LEN_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .ratioSel(ratioSel), .divIn(divIn),
    .slaveMode(slaveMode), .strb(strb),
    .atLowEnd(atLowEnd), .atHighEnd(atHighEnd), .atLhEnd(atLhEnd),
    .atHlEnd(atHlEnd), .atZero(atZero), .atMid(atMid)
  );

  sclControl uCtl (
    .clk(clk), .rstN(rstN), .enable(enable), .sclIn(sclIn),
    .atLowEnd(atLowEnd), .atHighEnd(atHighEnd), .atLhEnd(atLhEnd),
    .atHlEnd(atHlEnd), .atZero(atZero), .atMid(atMid),
    .strb(strb), .sclOe(sclOe), .fallStb(fallStb),
    .riseStb(riseStb), .midHighStb(midHighStb)
  );
endmodule

// File: tb/sim_sclClockGen.sv
`timescale 1ns/1ps
module sim_sclClockGen;
  localparam int DIV_W  = 3;
  localparam int OVH    = 8;
  localparam int DMAX   = (1 << DIV_W) - 1;
  localparam int HALF   = OVH / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [1:0] ratioSel = 2'd0;
  logic [DIV_W+1:0] divIn = '0;
  logic slaveMode = 1'b0;
  logic stretchHold = 1'b0;
  logic sclIn, sclOe, fallStb, riseStb, midHighStb;
  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  assign sclIn = !sclOe && !stretchHold;

  always #2 clk = ~clk;

  sclClockGen #(.DIV_W(DIV_W), .OVH(OVH)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .ratioSel(ratioSel),
    .divIn(divIn), .slaveMode(slaveMode), .sclIn(sclIn), .sclOe(sclOe),
    .fallStb(fallStb), .riseStb(riseStb), .midHighStb(midHighStb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int nLowOf(input int r);
    return (r == 1) ? 6 : (r == 2) ? 11 : 4;
  endfunction
  function automatic int nHighOf(input int r);
    return (r == 1) ? 3 : (r == 2) ? 6 : 4;
  endfunction
  function automatic int divOf(input int d, input int slv);
    int e;
    e = (d > DMAX) ? DMAX : d;
    if (slv != 0 && e == 0) e = 1;
    return e;
  endfunction

  // Starts from a disabled generator, enables it and measures one period.
  task automatic measure(input int r, input int d, input int slv);
    int lowE, highE, tOe, tRise, tMid, tPer;
    string tag;
    lowE  = nLowOf(r) * (divOf(d, slv) + 1);
    highE = nHighOf(r) * (divOf(d, slv) + 1);
    tag = (r == 3) ? "R2" : (d > DMAX) ? "R5" : (slv != 0 && d == 0) ? "R4" : "R1";
    @(negedge clk);
    enable = 1'b0; ratioSel = 2'(r); divIn = (DIV_W+2)'(d); slaveMode = slv[0];
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    chk(fallStb && sclOe, "R6 fall one cycle after enable", int'(fallStb), 1);
    tOe = -1; tRise = -1; tMid = -1; tPer = -1;
    for (int t = 1; t < 2000; t++) begin
      @(negedge clk);
      if (!sclOe && tOe < 0) tOe = t;
      if (riseStb && tRise < 0) tRise = t;
      if (midHighStb && tMid < 0) tMid = t;
      if (fallStb) begin tPer = t; break; end
    end
    chk(tOe == lowE, tag, tOe, lowE);
    chk(tPer == lowE + highE + OVH, {tag, " R3 period"}, tPer, lowE + highE + OVH);
    chk(tRise == lowE + HALF, "R8 rise strobe", tRise, lowE + HALF);
    chk(tMid == lowE + HALF + highE / 2, "R8 mid strobe", tMid, lowE + HALF + highE / 2);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks + 1, nFails);
      $finish;
    end
  end

  initial begin
    int tOe, tRise, tPer, tRel;
    bit quiet;
    // Reset state
    #1;
    chk(!sclOe && !fallStb && !riseStb && !midHighStb, "R6 reset released", int'(sclOe), 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // Disabled: nothing happens
    quiet = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sclOe || fallStb || riseStb || midHighStb) quiet = 1'b0;
    end
    chk(quiet, "R6 disabled stays released", int'(quiet), 1);

    // Full sweep of ratio, divider and slave mode
    for (int r = 0; r < 4; r++)
      for (int d = 0; d < 10; d++)
        for (int s = 0; s < 2; s++)
          measure(r, d, s);

    // Clock stretching: R7
    @(negedge clk);
    enable = 1'b0; ratioSel = 2'd0; divIn = '0; slaveMode = 1'b0;
    @(negedge clk);
    enable = 1'b1; stretchHold = 1'b1;
    @(negedge clk);
    tOe = -1; tRise = -1; tRel = -1; quiet = 1'b1;
    for (int t = 1; t < 500; t++) begin
      @(negedge clk);
      if (!sclOe && tOe < 0) tOe = t;
      if (riseStb && tRise < 0) tRise = t;
      if (tOe > 0 && tRel < 0 && (riseStb || midHighStb || fallStb)) quiet = 1'b0;
      if (tOe > 0 && tRel < 0 && t == tOe + 7) begin
        stretchHold = 1'b0;
        tRel = t;
      end
      if (tRise > 0) break;
    end
    chk(quiet, "R7 no strobe while line held low", int'(quiet), 1);
    chk(tRise == tRel + HALF, "R7 rise after line high", tRise, tRel + HALF);

    // Mid-period configuration change: R9
    @(negedge clk);
    enable = 1'b0; ratioSel = 2'd0; divIn = '0;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    tOe = -1; tPer = -1;
    for (int t = 1; t < 500; t++) begin
      @(negedge clk);
      if (t == 1) ratioSel = 2'd2;
      if (!sclOe && tOe < 0) tOe = t;
      if (fallStb) begin tPer = t; break; end
    end
    chk(tOe == 4 && tPer == 8 + OVH, "R9 current period unchanged", tPer, 8 + OVH);
    tOe = -1;
    for (int t = 1; t < 500; t++) begin
      @(negedge clk);
      if (!sclOe) begin tOe = t; break; end
    end
    chk(tOe == 11, "R9 next period uses new ratio", tOe, 11);

    // Disable mid-run releases immediately: R6
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    quiet = !sclOe && !fallStb && !riseStb && !midHighStb;
    chk(quiet, "R6 disable releases line", int'(sclOe), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule